// File: doc/BRIEF.md
# Port Pin Mode Controller

This block sits between the software-visible settings of one general-purpose I/O port and the pads of that port. It holds three per-pin settings: a data latch, a drive-style selector (push-pull or open-drain) and an input-style selector (analog or digital). Each is loaded through a narrow write bus. From these settings, a global pullup kill bit and per-pin routing information, it computes the high-side and low-side drive enables, the weak pullup enable and the digital input buffer enable for every pad.

The routing logic tells the block, for each pin, whether a peripheral owns the pin, whether that peripheral uses it as an input, and what level the peripheral wants to drive. A pin owned by a peripheral input never drives. A pin owned by a peripheral output takes its level from the peripheral while keeping its drive style. Pins set to analog lose their input buffer, pullup and digital read value, and are flagged back to the routing logic so that no digital function is placed on them.

Pad levels reach the read port through a two-stage synchronizer. Analog pins read as zero no matter what level is on the pad.

Top module: `port_pin_ctrl`

## Requirements
- R1: After reset the data latch holds all ones, every pin is open-drain and digital. So every pullup and input buffer is on, no driver is enabled and the skip mask is zero.
- R2: While `pu_off_all` is 1, every bit of `pu_en` is 0.
- R3: A pin whose low-side driver is enabled has its pullup off.
- R4: In open-drain mode (`omode` bit 0) a drive level of 1 enables neither driver. A level of 0 enables only the low-side driver.
- R5: In push-pull mode (`omode` bit 1) a level of 1 enables only the high-side driver and a level of 0 enables only the low-side driver. Both drivers of a pin are never enabled together.
- R6: A pin with both `rt_assigned` and `rt_is_input` set has both drivers off, whatever the register contents.
- R7: A pin with `rt_assigned` set and `rt_is_input` clear uses `rt_out_val` as its drive level instead of the data latch, and its drive style still applies.
- R8: An `imode` bit of 0 selects analog mode for that pin. The pin then has its input buffer off, its pullup off, its read bit at 0 and its skip bit at 1. Its drivers are unchanged by the mode.
- R9: A level on `pad_in` of a digital pin shows on `port_rd` after the second rising clock edge that samples it, and not after the first.
- R10: A write with `wr_en` high loads the data latch when `wr_sel` is 0, the drive-style register when it is 1 and the input-style register when it is 2. `wr_sel` equal to 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 data, 1 drive style, 2 input style |
| wr_data | input | 8 | Write value, one bit per pin |
| pu_off_all | input | 1 | Turns off all pullups of the port |
| rt_assigned | input | 8 | Pin owned by a routed peripheral |
| rt_is_input | input | 8 | Owning peripheral uses the pin as an input |
| rt_out_val | input | 8 | Level the owning peripheral drives |
| pad_in | input | 8 | Raw pad levels |
| drv_hi_en | output | 8 | High-side driver enable |
| drv_lo_en | output | 8 | Low-side driver enable |
| pu_en | output | 8 | Weak pullup enable |
| ibuf_en | output | 8 | Digital input buffer enable |
| port_rd | output | 8 | Synchronized read value |
| skip_mask | output | 8 | Pins the routing logic must pass over |

## Verification
The pullup enable depends on three things that can change in the same cycle: the global kill bit, the analog selection and the automatic release when a pin drives low. A routing change can also flip the drive level in the same cycle that a register write lands. The sweep changes the routing inputs, the kill bit and the pad levels on one edge. It then rewrites all three registers on the next cycles, so every pin passes through mixed states in which more than one cause of pullup release is active at once. A behavioural model is compared with all six outputs after every rising edge. It covers all 64 per-pin combinations of level, style, mode, ownership, direction and peripheral level, with the kill bit both off and on.

// File: rtl/port_pin_ctrl.sv
`timescale 1ns/1ps
module port_pin_ctrl #(
  parameter int PINS = 8,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [PINS-1:0] wr_data,
  input  logic            pu_off_all,
  input  logic [PINS-1:0] rt_assigned,
  input  logic [PINS-1:0] rt_is_input,
  input  logic [PINS-1:0] rt_out_val,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] drv_hi_en,
  output logic [PINS-1:0] drv_lo_en,
  output logic [PINS-1:0] pu_en,
  output logic [PINS-1:0] ibuf_en,
  output logic [PINS-1:0] port_rd,
  output logic [PINS-1:0] skip_mask
);
  localparam logic [SELW-1:0] SEL_DATA  = SELW'(0);
  localparam logic [SELW-1:0] SEL_OMODE = SELW'(1);
  localparam logic [SELW-1:0] SEL_IMODE = SELW'(2);

  logic [PINS-1:0] latch_q, omode_q, imode_q;
  logic [PINS-1:0] sync1_q, sync2_q;
  logic [PINS-1:0] per_in, per_out, level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      omode_q <= '0;
      imode_q <= '1;
    end else if (wr_en) begin
      if (wr_sel == SEL_DATA)  latch_q <= wr_data;
      if (wr_sel == SEL_OMODE) omode_q <= wr_data;
      if (wr_sel == SEL_IMODE) imode_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign per_in  = rt_assigned & rt_is_input;
  assign per_out = rt_assigned & ~rt_is_input;
  assign level   = (per_out & rt_out_val) | (~per_out & latch_q);

  assign drv_hi_en = ~per_in & omode_q & level;
  assign drv_lo_en = ~per_in & ~level;
  assign pu_en     = {PINS{~pu_off_all}} & imode_q & ~drv_lo_en;
  assign ibuf_en   = imode_q;
  assign skip_mask = ~imode_q;
  assign port_rd   = sync2_q & imode_q;

  p_no_crossfire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hi_en & drv_lo_en) == '0);
  p_pu_vs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & drv_lo_en) == '0);
  p_global_kill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pu_off_all |-> pu_en == '0);
  p_periph_in_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_hi_en | drv_lo_en) & rt_assigned & rt_is_input) == '0);
  p_analog_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_en | port_rd | ibuf_en) & skip_mask) == '0);
endmodule

// File: tb/port_pin_ctrl_bench.sv
`timescale 1ns/1ps
module port_pin_ctrl_bench;
  localparam int PINS = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [PINS-1:0] wr_data = '0;
  logic pu_off_all = 1'b0;
  logic [PINS-1:0] rt_assigned = '0, rt_is_input = '0, rt_out_val = '0, pad_in = '0;
  logic [PINS-1:0] drv_hi_en, drv_lo_en, pu_en, ibuf_en, port_rd, skip_mask;

  int checks = 0, errors = 0, cycles = 0;
  bit run = 0, done = 0;

  logic [PINS-1:0] m_data, m_omode, m_imode;
  logic [PINS-1:0] padq[$];

  always #2.5 clk = ~clk;

  port_pin_ctrl u_port_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pu_off_all(pu_off_all), .rt_assigned(rt_assigned), .rt_is_input(rt_is_input),
    .rt_out_val(rt_out_val), .pad_in(pad_in), .drv_hi_en(drv_hi_en),
    .drv_lo_en(drv_lo_en), .pu_en(pu_en), .ibuf_en(ibuf_en), .port_rd(port_rd),
    .skip_mask(skip_mask));

  task automatic chk(input string req, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '1; m_omode = '0; m_imode = '1;
      padq.delete();
    end else begin
      if (wr_en) begin
        if (wr_sel == 2'd0) m_data = wr_data;
        else if (wr_sel == 2'd1) m_omode = wr_data;
        else if (wr_sel == 2'd2) m_imode = wr_data;
      end
      padq.push_back(pad_in);
      if (padq.size() > 4) void'(padq.pop_front());
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && run) begin
      logic [PINS-1:0] e_hi, e_lo, e_pu, e_ib, e_rd, e_sk, sync;
      sync = (padq.size() >= 2) ? padq[padq.size()-2] : '0;
      for (int i = 0; i < PINS; i++) begin
        bit lvl, dig;
        dig = m_imode[i];
        lvl = (rt_assigned[i] && !rt_is_input[i]) ? rt_out_val[i] : m_data[i];
        e_hi[i] = 0; e_lo[i] = 0;
        if (!(rt_assigned[i] && rt_is_input[i])) begin
          if (lvl) e_hi[i] = m_omode[i];
          else e_lo[i] = 1;
        end
        e_pu[i] = dig && !pu_off_all && !e_lo[i];
        e_ib[i] = dig;
        e_sk[i] = !dig;
        e_rd[i] = dig ? sync[i] : 1'b0;
      end
      chk("R4 R5 R6 R7 high-side", drv_hi_en, e_hi);
      chk("R4 R5 R6 R7 low-side", drv_lo_en, e_lo);
      chk("R2 R3 R8 pullup", pu_en, e_pu);
      chk("R8 input buffer", ibuf_en, e_ib);
      chk("R8 skip", skip_mask, e_sk);
      chk("R9 R8 read", port_rd, e_rd);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [PINS-1:0] val);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = val;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic settle();
    @(posedge clk); #1.5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R1 reset state
    chk("R1 pullup", pu_en, 8'hFF);
    chk("R1 high-side", drv_hi_en, 8'h00);
    chk("R1 low-side", drv_lo_en, 8'h00);
    chk("R1 input buffer", ibuf_en, 8'hFF);
    chk("R1 skip", skip_mask, 8'h00);
    run = 1;
    // R10: select 3 ignored
    wr(2'd3, 8'h00);
    settle();
    chk("R10 ignored select low-side", drv_lo_en, 8'h00);
    chk("R10 ignored select skip", skip_mask, 8'h00);
    // R4 open-drain levels
    wr(2'd0, 8'h3C);
    settle();
    chk("R4 od low-side", drv_lo_en, 8'hC3);
    chk("R4 od high-side", drv_hi_en, 8'h00);
    // R5 push-pull, R3 pullup release
    wr(2'd1, 8'hFF);
    settle();
    chk("R5 pp high-side", drv_hi_en, 8'h3C);
    chk("R3 pullup release", pu_en, 8'h3C);
    // R2 global kill
    @(negedge clk); pu_off_all = 1;
    settle();
    chk("R2 global kill", pu_en, 8'h00);
    @(negedge clk); pu_off_all = 0;
    // R9 synchronizer latency
    @(negedge clk); pad_in = 8'hA5;
    @(posedge clk); #1.5;
    chk("R9 not after first edge", port_rd, 8'h00);
    @(posedge clk); #1.5;
    chk("R9 after second edge", port_rd, 8'hA5);
    // R8 analog: drivers untouched, read zero
    wr(2'd2, 8'h0F);
    settle();
    chk("R8 analog read", port_rd, 8'h05);
    chk("R8 analog drivers kept", drv_hi_en, 8'h3C);
    // R6 and R7 directed
    @(negedge clk); rt_assigned = 8'hFF; rt_is_input = 8'h0F; rt_out_val = 8'h50;
    settle();
    chk("R6 periph input quiet", drv_lo_en & 8'h0F, 8'h00);
    chk("R7 periph output level", drv_hi_en, 8'h50);
    // exhaustive sweep
    for (int c = 0; c < 128; c++) begin
      logic [PINS-1:0] d, o, im;
      @(negedge clk);
      pu_off_all = c[6];
      pad_in = PINS'(c * 37 + 11);
      for (int i = 0; i < PINS; i++) begin
        int k;
        k = (c + i * 8) & 63;
        d[i] = k[0]; o[i] = k[1]; im[i] = k[2];
        rt_assigned[i] = k[3]; rt_is_input[i] = k[4]; rt_out_val[i] = k[5];
      end
      wr(2'd0, d);
      wr(2'd1, o);
      wr(2'd2, im);
      repeat (2) @(negedge clk);
    end
    run = 0;
    done = 1;
  end

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk); cycles++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected done", cycles);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule